// File: doc/BRIEF.md
# Clock-Register Overlay Decoder with Supply Guard

This block sits between a host bus and an external static RAM whose address space also holds a small file of clock, alarm, watchdog and control registers. The host presents a 19-bit byte address with active-low chip enable, output enable and write enable. The block passes these through to the RAM. When the address falls in the topmost 16-byte window, it also raises a select, a register index and a write strobe for the internal register file. During such an access the RAM output enable is held inactive, so the register file alone drives the data bus and the register window overlays the RAM without contention.

A digital supply-fail input stands in for the analog tolerance comparator. While that input is high, the RAM is deselected at once and its output enable is forced off. Write permission for the register file is decided when each bus cycle starts and then held until the cycle ends. A failure that begins inside a cycle therefore lets that cycle finish, and blocks the next one. A cycle starts at the first rising clock edge that sees the host chip enable low. It ends at a rising edge that sees it high, so two cycles need at least one such edge between them.

Top module: `tk_guard`

## Requirements
- R1: After reset, with the host chip enable high and the supply good, `ram_ce_n`=1, `ram_oe_n`=1, `reg_sel`=0 and `reg_we`=0.
- R2: With the supply good and the host chip enable low, an address from 0x7FFF0 to 0x7FFFF drives `reg_sel`=1 and `reg_idx` equal to address bits [3:0].
- R3: Whenever `reg_sel` is 1, `ram_oe_n` is 1, even when `host_oe_n` is 0.
- R4: For any address below 0x7FFF0 with the supply good, `ram_ce_n` equals `host_ce_n`. `ram_oe_n` is 0 exactly when `host_ce_n` and `host_oe_n` are both 0, and `reg_sel` is 0.
- R5: `reg_we` is 1 exactly when `reg_sel` is 1, `host_we_n` is 0 and the current cycle holds write permission.
- R6: While `pwr_fail` is 1, `ram_ce_n` and `ram_oe_n` are both 1 in the same cycle, whatever the host enables and the address are.
- R7: If `pwr_fail` is 1 when a cycle starts, `reg_sel` and `reg_we` stay 0 for the whole of that cycle, even if `pwr_fail` falls before the cycle ends.
- R8: If `pwr_fail` rises after a cycle has started with the supply good, `reg_sel` and `reg_we` keep their values until that cycle ends. The next cycle to start while `pwr_fail` is 1 is blocked.
- R9: Address 0x7FFEF goes to the RAM (`reg_sel`=0, RAM output enabled on a read) and address 0x7FFF0 goes to the registers with `reg_idx`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_addr | input | 19 | Host byte address |
| host_ce_n | input | 1 | Host chip enable, active low |
| host_oe_n | input | 1 | Host output enable, active low |
| host_we_n | input | 1 | Host write enable, active low |
| pwr_fail | input | 1 | Supply out of tolerance, active high |
| ram_ce_n | output | 1 | Chip enable to external RAM, active low |
| ram_oe_n | output | 1 | Output enable to external RAM, active low |
| reg_sel | output | 1 | Select to the internal register file |
| reg_we | output | 1 | Write strobe to the internal register file |
| reg_idx | output | 4 | Register index within the top window |

## Verification
The bench builds the block with its default parameters: a 19-bit address and a 4-bit register index. This places the window at 0x7FFF0 through 0x7FFFF, so both window edges can be reached directly with single accesses. The scenarios raise and drop the supply-fail input both before and after the first clock edge of a cycle. This makes visible the split between the RAM enables, which are cut immediately, and register write permission, which is latched per cycle.

// File: rtl/tk_guard_pkg.sv
package tk_guard_pkg;

  localparam int unsigned TK_ADDR_W  = 19;
  localparam int unsigned TK_IDX_W   = 4;
  localparam int unsigned TK_RST_STG = 2;

  typedef struct packed {
    logic active;
    logic hit;
    logic ok;
  } tk_access_t;

endpackage

// File: rtl/tk_rst_sync.sv
module tk_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_n_sync = chain_q[STAGES-1];

endmodule

// File: rtl/tk_addr_decode.sv
module tk_addr_decode #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              win_hit,
  output logic [IDX_W-1:0]  win_idx
);

  localparam int unsigned TAG_W = ADDR_W - IDX_W;

  logic [TAG_W-1:0] tag;

  always_comb begin
    tag     = addr[ADDR_W-1:IDX_W];
    win_hit = &tag;
    win_idx = addr[IDX_W-1:0];
  end

endmodule

// File: rtl/tk_cycle_track.sv
module tk_cycle_track (
  input  logic clk,
  input  logic rst_n,
  input  logic bus_ce_n,
  input  logic supply_bad,
  output logic in_cycle,
  output logic wr_ok
);

  logic in_cycle_q, in_cycle_d;
  logic perm_q, perm_d;
  logic perm_en;
  logic cyc_start;

  always_comb begin
    cyc_start  = !bus_ce_n && !in_cycle_q;
    in_cycle_d = !bus_ce_n;
    perm_en    = cyc_start;
    perm_d     = !supply_bad;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_cycle_q <= 1'b0;
      perm_q     <= 1'b0;
    end else begin
      in_cycle_q <= in_cycle_d;
      if (perm_en) perm_q <= perm_d;
    end
  end

  always_comb begin
    in_cycle = in_cycle_q;
    wr_ok    = in_cycle_q ? perm_q : !supply_bad;
  end

  // R7
  start_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle_q && !$past(in_cycle_q) && $past(supply_bad)) |-> !perm_q);

  // R8
  perm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_cycle_q && $past(in_cycle_q)) |-> $stable(perm_q));

endmodule

// File: rtl/tk_guard.sv
module tk_guard
  import tk_guard_pkg::*;
#(
  parameter int unsigned ADDR_W  = TK_ADDR_W,
  parameter int unsigned IDX_W   = TK_IDX_W,
  parameter int unsigned RST_STG = TK_RST_STG
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_ce_n,
  input  logic              host_oe_n,
  input  logic              host_we_n,
  input  logic              pwr_fail,
  output logic              ram_ce_n,
  output logic              ram_oe_n,
  output logic              reg_sel,
  output logic              reg_we,
  output logic [IDX_W-1:0]  reg_idx
);

  logic       rst_n_s;
  logic       hit;
  logic [IDX_W-1:0] idx;
  logic       in_cycle;
  logic       wr_ok;
  tk_access_t acc;

  tk_rst_sync #(.STAGES(RST_STG)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  tk_addr_decode #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_dec (
    .addr    (host_addr),
    .win_hit (hit),
    .win_idx (idx)
  );

  tk_cycle_track u_trk (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .bus_ce_n   (host_ce_n),
    .supply_bad (pwr_fail),
    .in_cycle   (in_cycle),
    .wr_ok      (wr_ok)
  );

  always_comb begin
    acc.active = !host_ce_n && rst_n_s;
    acc.hit    = hit;
    acc.ok     = wr_ok;
    ram_ce_n   = host_ce_n || pwr_fail;
    ram_oe_n   = host_ce_n || host_oe_n || acc.hit || pwr_fail;
    reg_sel    = acc.active && acc.hit && acc.ok;
    reg_we     = reg_sel && !host_we_n;
    reg_idx    = idx;
  end

  // R3
  oe_overlay_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_sel |-> ram_oe_n);

  // R6
  pf_deselect_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    pwr_fail |-> (ram_ce_n && ram_oe_n));

  // R5
  we_needs_sel_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_we |-> (reg_sel && !host_we_n));

  // R2
  sel_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_sel |-> (!host_ce_n && !ram_ce_n || pwr_fail));

  // R8
  sel_kept_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (in_cycle && $past(in_cycle) && $past(reg_sel) && !host_ce_n
     && $stable(host_addr)) |-> reg_sel);

endmodule

// File: tb/tk_guard_test.sv
module tk_guard_test;

  localparam int CLK_PERIOD = 10;

  logic        clk;
  logic        rst_n;
  logic [18:0] host_addr;
  logic        host_ce_n, host_oe_n, host_we_n, pwr_fail;
  logic        ram_ce_n, ram_oe_n, reg_sel, reg_we;
  logic [3:0]  reg_idx;

  int n_run;
  int n_fail;
  bit done;

  tk_guard uut (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr),
    .host_ce_n(host_ce_n), .host_oe_n(host_oe_n), .host_we_n(host_we_n),
    .pwr_fail(pwr_fail), .ram_ce_n(ram_ce_n), .ram_oe_n(ram_oe_n),
    .reg_sel(reg_sel), .reg_we(reg_we), .reg_idx(reg_idx)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // bundle: {ram_ce_n, ram_oe_n, reg_sel, reg_we}
  function automatic logic [31:0] outs();
    return {28'd0, ram_ce_n, ram_oe_n, reg_sel, reg_we};
  endfunction

  task automatic drive(input logic [18:0] a, input logic ce, input logic oe,
                       input logic we, input logic pf);
    @(negedge clk);
    host_addr = a; host_ce_n = ce; host_oe_n = oe; host_we_n = we; pwr_fail = pf;
    #2;
  endtask

  task automatic end_cycle();
    drive(19'h0, 1'b1, 1'b1, 1'b1, pwr_fail);
  endtask

  task automatic t_reset();
    chk("R1 idle outputs", outs(), 32'b1100);
  endtask

  task automatic t_ram_access();
    drive(19'h12345, 0, 0, 1, 0);
    chk("R4 ram read", outs(), 32'b0000);
    drive(19'h12345, 0, 1, 0, 0);
    chk("R4 ram write oe off", outs(), 32'b0100);
    end_cycle();
    chk("R4 ram idle", outs(), 32'b1100);
  endtask

  task automatic t_reg_access();
    drive(19'h7FFF5, 0, 0, 1, 0);
    chk("R2 reg read sel", outs(), 32'b0110);
    chk("R2 reg idx", {28'd0, reg_idx}, 32'h5);
    chk("R3 oe held off", {31'd0, ram_oe_n}, 32'd1);
    end_cycle();
    drive(19'h7FFFF, 0, 1, 0, 0);
    chk("R5 reg write strobe", outs(), 32'b0111);
    chk("R2 reg idx top", {28'd0, reg_idx}, 32'hF);
    end_cycle();
  endtask

  task automatic t_boundary();
    drive(19'h7FFEF, 0, 0, 1, 0);
    chk("R9 below window is ram", outs(), 32'b0000);
    end_cycle();
    drive(19'h7FFF0, 0, 0, 1, 0);
    chk("R9 window base", outs(), 32'b0110);
    chk("R9 window base idx", {28'd0, reg_idx}, 32'h0);
    end_cycle();
  endtask

  task automatic t_pf_immediate();
    drive(19'h00100, 0, 0, 1, 1);
    chk("R6 ram off on fail", outs(), 32'b1100);
    drive(19'h7FFF3, 0, 1, 0, 1);
    chk("R6 reg blocked on fail", outs(), 32'b1100);
    end_cycle();
    drive(19'h0, 1, 1, 1, 0);
  endtask

  task automatic t_pf_at_start();
    drive(19'h7FFF2, 0, 1, 0, 1);
    chk("R7 blocked at start", outs(), 32'b1100);
    drive(19'h7FFF2, 0, 1, 0, 0);
    chk("R7 stays blocked after recovery", outs(), 32'b0100);
    end_cycle();
    drive(19'h7FFF2, 0, 1, 0, 0);
    chk("R7 next cycle allowed", outs(), 32'b0111);
    end_cycle();
  endtask

  task automatic t_pf_mid();
    drive(19'h7FFF9, 0, 1, 0, 0);
    chk("R8 write begins", outs(), 32'b0111);
    drive(19'h7FFF9, 0, 1, 0, 1);
    chk("R8 write completes", {31'd0, reg_we}, 32'd1);
    chk("R6 ram off mid cycle", {30'd0, ram_ce_n, ram_oe_n}, 32'b11);
    drive(19'h7FFF9, 0, 1, 0, 1);
    chk("R8 still completing", {31'd0, reg_we}, 32'd1);
    end_cycle();
    drive(19'h7FFF9, 0, 1, 0, 1);
    drive(19'h7FFF9, 0, 1, 0, 0);
    chk("R8 next cycle blocked", {30'd0, reg_sel, reg_we}, 32'd0);
    end_cycle();
  endtask

  initial begin
    rst_n = 1'b0;
    host_addr = '0; host_ce_n = 1'b1; host_oe_n = 1'b1; host_we_n = 1'b1; pwr_fail = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #2;
    t_reset();
    t_ram_access();
    t_reg_access();
    t_boundary();
    t_pf_immediate();
    t_pf_at_start();
    t_pf_mid();
    if (!done) begin
      done = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      done = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule